// File: doc/BRIEF.md
# Quad-Rail Supervisor Fault Sequencer

This block is the digital decision stage that sits behind the comparators of a four-rail voltage supervisor. Each rail supplies two synchronous flags: `hi_below`, set when the upper divider tap has fallen under its trip point, and `lo_above`, set when the lower tap has risen over its trip point. Whether a flag means undervoltage or overvoltage depends on the polarity of the rail. Rails 1 and 2 are always positive. The polarity of rails 3 and 4 comes from a two-bit code that stands for a three-state select pin.

The block drives two active-low outputs, `uv_n` and `ov_n`. Both are held for a programmable number of clock cycles after the last fault clears. The hold timer restarts whenever any fault returns. The `mode_ctl` input has one of two meanings, chosen by the `LATCH_VARIANT` parameter. In the latch build it clears the overvoltage latch, and while held high it makes the output transparent. In the disable build it forces both outputs inactive. A supply-lockout flag overrides everything: it holds undervoltage asserted and keeps overvoltage cleared. A bypass flag removes the hold time from both outputs.

Top module: `rail_fault_seq`

## Requirements
- R1: Rails 1 and 2 (bit positions 0 and 1 of the flag vectors) are always positive. On a positive rail, `hi_below` signals undervoltage and `lo_above` signals overvoltage.
- R2: On a negative rail the meanings swap: `hi_below` signals overvoltage and `lo_above` signals undervoltage.
- R3: `pol_sel` sets the polarity of rails 3 and 4 (bit positions 2 and 3). 2'b11 makes both positive. 2'b00 makes both negative. 2'b01 and 2'b10 make rail 3 positive and rail 4 negative.
- R4: `uv_n` goes low on the clock edge that samples any undervoltage fault. It rises on the HOLD_CYCLES-th edge that samples all rails clear, counting from the first such edge.
- R5: An undervoltage fault that returns during the hold restarts the count, so the release comes a full HOLD_CYCLES edges after the new fault clears.
- R6: In the latch build with `mode_ctl` low, an asserted `ov_n` stays low after the fault and its hold are gone. It rises on the first edge that samples `mode_ctl` high, provided the hold has expired.
- R7: In the latch build with `mode_ctl` high, `ov_n` follows the same assert and release timing as `uv_n` does in R4.
- R8: In the latch build, driving `mode_ctl` low while the overvoltage hold is still counting latches `ov_n` low.
- R9: In the disable build with `mode_ctl` high and no lockout, both outputs are high one edge later, whatever the flags show.
- R10: While `lockout` is sampled high, `uv_n` is low and `ov_n` is high. After lockout ends, `uv_n` rises on the HOLD_CYCLES-th edge that samples lockout low, and any overvoltage fault seen during lockout is discarded.
- R11: In the disable build with `mode_ctl` high, lockout still drives `uv_n` low. `uv_n` rises on the first edge that samples lockout low.
- R12: With `bypass_hold` high, an output rises on the first edge that samples its fault source clear.
- R13: Reset puts `uv_n` low and `ov_n` high. With no faults, `uv_n` rises on the HOLD_CYCLES-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_below | input | NUM_RAILS | Per rail: the upper tap is below its threshold |
| lo_above | input | NUM_RAILS | Per rail: the lower tap is above its threshold |
| pol_sel | input | 2 | Polarity code for rails 3 and 4 |
| lockout | input | 1 | Supply undervoltage lockout flag |
| bypass_hold | input | 1 | Release both outputs with no hold time |
| mode_ctl | input | 1 | Latch clear (latch build) or output disable (disable build) |
| uv_n | output | 1 | Active-low undervoltage output |
| ov_n | output | 1 | Active-low overvoltage output |

## Verification
A polarity decode error sends a fault to the wrong output. It shows one edge after the flag is applied, so the vector table sweeps every polarity code against flags on each rail. A hold counter that starts at the wrong value, or that fails to restart, moves the rising edge of an output by some number of cycles. The bench therefore samples one cycle before and one cycle after the expected release. A latch that fails to set or to clear only shows up many cycles later, or at the edge where `mode_ctl` changes, and the latch and lockout tests sample at those edges.

// File: rtl/rail_seq_pkg.sv
// Package rail_seq_pkg
// Shared polarity encoding for the quad-rail fault sequencer.
// Assumes exactly two rails take their polarity from the select code.
package rail_seq_pkg;

    // Two-bit image of the three-state polarity select pin
    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_OPEN = 2'b01,
        POL_RSVD = 2'b10,
        POL_HIGH = 2'b11
    } pol_code_e;

    // Number of rails whose polarity the select code governs
    localparam int SEL_RAILS = 2;

    // Returns the negative-rail mask for the selectable rails: bit 0 = rail 3, bit 1 = rail 4
    function automatic logic [SEL_RAILS-1:0] neg_mask_of(input logic [1:0] code);
        logic [SEL_RAILS-1:0] mask;
        case (pol_code_e'(code))
            POL_HIGH: mask = 2'b00;
            POL_LOW:  mask = 2'b11;
            default:  mask = 2'b10;   // open, and the unused code treated as open
        endcase
        return mask;
    endfunction

endpackage

// File: rtl/rail_pol_map.sv
// Module rail_pol_map
// Turns per-rail comparator flags into undervoltage and overvoltage fault
// vectors according to each rail's polarity, then ORs them across rails.
// Assumes the first FIXED_POS rails are always positive and the rest
// (exactly rail_seq_pkg::SEL_RAILS of them) take their polarity from pol_sel.
module rail_pol_map
    import rail_seq_pkg::*;
#(
    parameter int NUM_RAILS = 4,
    parameter int FIXED_POS = 2
) (
    input  logic [NUM_RAILS-1:0] hi_below,
    input  logic [NUM_RAILS-1:0] lo_above,
    input  logic [1:0]           pol_sel,
    output logic [NUM_RAILS-1:0] uv_rail,
    output logic [NUM_RAILS-1:0] ov_rail,
    output logic                 uv_any,
    output logic                 ov_any
);

    logic [SEL_RAILS-1:0] neg_mask;

    // Decode the select code into a negative-rail mask
    always_comb begin
        neg_mask = neg_mask_of(pol_sel);
    end

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        if (g < FIXED_POS) begin : g_fixed
            // Fixed positive rail: the upper tap gives UV, the lower tap gives OV
            always_comb begin
                uv_rail[g] = hi_below[g];
                ov_rail[g] = lo_above[g];
            end
        end else begin : g_sel
            logic is_neg;
            assign is_neg = neg_mask[g-FIXED_POS];
            // Selectable rail: the tap roles swap when the rail is negative
            always_comb begin
                uv_rail[g] = is_neg ? lo_above[g] : hi_below[g];
                ov_rail[g] = is_neg ? hi_below[g] : lo_above[g];
            end
        end
    end

    // Combine the per-rail faults into the two shared fault sources
    always_comb begin
        uv_any = |uv_rail;
        ov_any = |ov_rail;
    end

endmodule

// File: rtl/rail_holdoff.sv
// Module rail_holdoff
// Restartable release timer. A fault sets it active and clears the count.
// Each clear cycle advances the count, and the timer releases on the
// HOLD_CYCLES-th clear edge, or on the first one when bypass is high.
// kill forces it idle. Assumes HOLD_CYCLES >= 1.
module rail_holdoff #(
    parameter int   HOLD_CYCLES  = 8,
    parameter logic RESET_ACTIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic kill,
    input  logic bypass,
    output logic active_nxt,
    output logic active_q
);

    localparam int             CW   = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0]  LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Next-state rule for the active flag and the clear-cycle count
    always_comb begin
        active_nxt = active_q;
        cnt_nxt    = cnt_q;
        if (kill) begin
            active_nxt = 1'b0;
            cnt_nxt    = '0;
        end else if (fault) begin
            active_nxt = 1'b1;
            cnt_nxt    = '0;
        end else if (active_q) begin
            if (bypass || (cnt_q == LAST)) begin
                active_nxt = 1'b0;
                cnt_nxt    = '0;
            end else begin
                cnt_nxt = cnt_q + 1'b1;
            end
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= RESET_ACTIVE;
            cnt_q    <= '0;
        end else begin
            active_q <= active_nxt;
            cnt_q    <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ov_latch_ctrl.sv
// Module ov_latch_ctrl
// Builds the next overvoltage assert decision from the hold timer.
// In the latch build, a low mode_ctl latches an asserted output until
// mode_ctl goes high. In the disable build, a high mode_ctl forces the
// output off. Lockout always clears it. Assumes the timer is already killed
// during lockout.
module ov_latch_ctrl #(
    parameter bit LATCH_VARIANT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ctl,
    input  logic lockout,
    input  logic ov_fault,
    input  logic ov_active_q,
    input  logic ov_active_nxt,
    output logic ov_assert_nxt
);

    if (LATCH_VARIANT) begin : g_latch
        logic latched_q;
        logic latched_nxt;

        // Latch sets while the control is low and the output is, or becomes, asserted
        always_comb begin
            latched_nxt   = !lockout && !mode_ctl && (ov_fault || ov_active_q || latched_q);
            ov_assert_nxt = !lockout && (latched_nxt || ov_active_nxt);
        end

        // Latch storage
        always_ff @(posedge clk) begin
            if (!rst_n) latched_q <= 1'b0;
            else        latched_q <= latched_nxt;
        end
    end else begin : g_disable
        logic unused_sig;
        assign unused_sig = ^{clk, rst_n, ov_fault, ov_active_q};

        // Disable overrides the timer, and lockout clears the output
        always_comb begin
            ov_assert_nxt = !lockout && !mode_ctl && ov_active_nxt;
        end
    end

endmodule

// File: rtl/rail_fault_seq.sv
// Module rail_fault_seq
// Top of the quad-rail fault sequencer. It maps comparator flags to UV/OV
// faults, runs one hold timer per output, applies the latch or disable
// variant and the lockout overrides, and registers the active-low outputs.
// Assumes all inputs are synchronous to clk.
module rail_fault_seq #(
    parameter int NUM_RAILS     = 4,
    parameter int HOLD_CYCLES   = 8,
    parameter bit LATCH_VARIANT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] hi_below,
    input  logic [NUM_RAILS-1:0] lo_above,
    input  logic [1:0]           pol_sel,
    input  logic                 lockout,
    input  logic                 bypass_hold,
    input  logic                 mode_ctl,
    output logic                 uv_n,
    output logic                 ov_n
);

    localparam int  FIXED_POS = NUM_RAILS - rail_seq_pkg::SEL_RAILS;
    localparam bit  HAS_DIS   = !LATCH_VARIANT;

    logic [NUM_RAILS-1:0] uv_rail;
    logic [NUM_RAILS-1:0] ov_rail;
    logic                 uv_any;
    logic                 ov_any;
    logic                 uv_act_nxt, uv_act_q;
    logic                 ov_act_nxt, ov_act_q;
    logic                 ov_assert_nxt;
    logic                 uv_assert_nxt;
    logic                 dis_on;
    logic                 uv_q, ov_q;
    logic                 unused_rails;

    assign unused_rails = ^{uv_rail, ov_rail};

    rail_pol_map #(
        .NUM_RAILS (NUM_RAILS),
        .FIXED_POS (FIXED_POS)
    ) u_map (
        .hi_below (hi_below),
        .lo_above (lo_above),
        .pol_sel  (pol_sel),
        .uv_rail  (uv_rail),
        .ov_rail  (ov_rail),
        .uv_any   (uv_any),
        .ov_any   (ov_any)
    );

    // UV timer: lockout counts as a fault, so lockout exit releases through the hold
    rail_holdoff #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .RESET_ACTIVE (1'b1)
    ) u_uv_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (uv_any || lockout),
        .kill       (1'b0),
        .bypass     (bypass_hold),
        .active_nxt (uv_act_nxt),
        .active_q   (uv_act_q)
    );

    // OV timer: lockout blocks and clears it
    rail_holdoff #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .RESET_ACTIVE (1'b0)
    ) u_ov_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (ov_any && !lockout),
        .kill       (lockout),
        .bypass     (bypass_hold),
        .active_nxt (ov_act_nxt),
        .active_q   (ov_act_q)
    );

    ov_latch_ctrl #(
        .LATCH_VARIANT (LATCH_VARIANT)
    ) u_ov_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_ctl      (mode_ctl),
        .lockout       (lockout),
        .ov_fault      (ov_any),
        .ov_active_q   (ov_act_q),
        .ov_active_nxt (ov_act_nxt),
        .ov_assert_nxt (ov_assert_nxt)
    );

    // UV decision: under disable only lockout asserts, with no hold on exit
    always_comb begin
        dis_on        = HAS_DIS && mode_ctl;
        uv_assert_nxt = dis_on ? lockout : uv_act_nxt;
    end

    // Output registers; reset matches the lockout state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uv_q <= 1'b1;
            ov_q <= 1'b0;
        end else begin
            uv_q <= uv_assert_nxt;
            ov_q <= ov_assert_nxt;
        end
    end

    // Active-low pin images
    always_comb begin
        uv_n = !uv_q;
        ov_n = !ov_q;
    end

endmodule

// File: rtl/rail_fault_seq_chk.sv
// Module rail_fault_seq_chk
// Property checker for rail_fault_seq, bound to every instance. It relates
// the shared fault sources from the polarity map to the registered outputs.
module rail_fault_seq_chk #(
    parameter int HOLD_CYCLES   = 8,
    parameter bit LATCH_VARIANT = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic uv_any,
    input logic ov_any,
    input logic lockout,
    input logic bypass_hold,
    input logic mode_ctl,
    input logic uv_n,
    input logic ov_n
);

    localparam int RW = $clog2(HOLD_CYCLES + 1) + 1;

    logic          dis_act;
    logic [RW-1:0] clear_run;

    assign dis_act = !LATCH_VARIANT && mode_ctl;

    // Counts consecutive sampled cycles with no UV source, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                              clear_run <= '0;
        else if (uv_any || lockout)              clear_run <= '0;
        else if (clear_run < RW'(HOLD_CYCLES))   clear_run <= clear_run + 1'b1;
    end

    AST_LOCK_UV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !uv_n);                                             // R10
    AST_LOCK_OV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> ov_n);                                              // R10
    AST_UV_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_any && !dis_act) |=> !uv_n);                                // R4
    AST_OV_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_any && !lockout && !dis_act) |=> !ov_n);                    // R7
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_hold && !dis_act && !uv_n && clear_run < RW'(HOLD_CYCLES - 1)) |=> !uv_n); // R4
    AST_DISABLE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_act && !lockout) |=> (uv_n && ov_n));                      // R9
    AST_BYPASS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_hold && !uv_any && !lockout) |=> uv_n);                 // R12
    AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (LATCH_VARIANT && !mode_ctl && !lockout && !ov_n) |=> !ov_n);   // R6

endmodule

bind rail_fault_seq rail_fault_seq_chk #(
    .HOLD_CYCLES   (HOLD_CYCLES),
    .LATCH_VARIANT (LATCH_VARIANT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_any      (uv_any),
    .ov_any      (ov_any),
    .lockout     (lockout),
    .bypass_hold (bypass_hold),
    .mode_ctl    (mode_ctl),
    .uv_n        (uv_n),
    .ov_n        (ov_n)
);

// File: tb/test_rail_fault_seq.sv
// Testbench for rail_fault_seq: runs a latch build and a disable build side by side.
module test_rail_fault_seq;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] hi_below, lo_above;
    logic [1:0] pol_sel;
    logic       lockout, bypass_hold, latch_ctl, dis_ctl;
    logic       uv_n, ov_n, d_uv_n, d_ov_n;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #5 clk = ~clk;

    rail_fault_seq #(.NUM_RAILS(4), .HOLD_CYCLES(HOLD), .LATCH_VARIANT(1'b1)) i_rail_fault_seq (
        .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
        .pol_sel(pol_sel), .lockout(lockout), .bypass_hold(bypass_hold),
        .mode_ctl(latch_ctl), .uv_n(uv_n), .ov_n(ov_n));

    rail_fault_seq #(.NUM_RAILS(4), .HOLD_CYCLES(HOLD), .LATCH_VARIANT(1'b0)) i_rail_fault_seq_dis (
        .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
        .pol_sel(pol_sel), .lockout(lockout), .bypass_hold(bypass_hold),
        .mode_ctl(dis_ctl), .uv_n(d_uv_n), .ov_n(d_ov_n));

    // Vector fields: pol[11:10] hi_below[9:6] lo_above[5:2] exp_uv_n[1] exp_ov_n[0]
    localparam logic [11:0] VEC [12] = '{
        {2'b11, 4'b0001, 4'b0000, 2'b01},
        {2'b11, 4'b0000, 4'b0010, 2'b10},
        {2'b11, 4'b0100, 4'b0000, 2'b01},
        {2'b00, 4'b0100, 4'b0000, 2'b10},
        {2'b00, 4'b0000, 4'b1000, 2'b01},
        {2'b01, 4'b0100, 4'b0000, 2'b01},
        {2'b01, 4'b1000, 4'b0000, 2'b10},
        {2'b10, 4'b0000, 4'b1000, 2'b01},
        {2'b11, 4'b0000, 4'b1000, 2'b10},
        {2'b00, 4'b0010, 4'b0000, 2'b01},
        {2'b01, 4'b0001, 4'b0100, 2'b00},
        {2'b10, 4'b1000, 4'b0100, 2'b10}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hi_below = '0; lo_above = '0; pol_sel = 2'b11;
        lockout = 1'b0; bypass_hold = 1'b0; latch_ctl = 1'b1; dis_ctl = 1'b0;
        step(3);
        check("R13 reset uv", uv_n, 1'b0);
        check("R13 reset ov", ov_n, 1'b1);
        check("R13 reset uv dis", d_uv_n, 1'b0);
        rst_n = 1'b1;
        step(HOLD - 1);
        check("R13 hold before release", uv_n, 1'b0);
        step(1);
        check("R13 release", uv_n, 1'b1);
        check("R13 ov stays", ov_n, 1'b1);

        // Polarity table, with the hold bypassed (R1 R2 R3)
        bypass_hold = 1'b1;
        for (int i = 0; i < 12; i++) begin
            string tag;
            tag = (i == 0 || i == 1 || i == 9) ? "R1" : (i == 3 || i == 4) ? "R2" : "R3";
            pol_sel  = VEC[i][11:10];
            hi_below = VEC[i][9:6];
            lo_above = VEC[i][5:2];
            step(1);
            check($sformatf("%s vec %0d uv", tag, i), uv_n, VEC[i][1]);
            check($sformatf("%s vec %0d ov", tag, i), ov_n, VEC[i][0]);
            hi_below = '0; lo_above = '0;
            step(2);
        end
        bypass_hold = 1'b0; pol_sel = 2'b11;

        // R4: hold length after an undervoltage fault
        hi_below = 4'b0001; step(1);
        check("R4 assert", uv_n, 1'b0);
        hi_below = '0; step(HOLD - 1);
        check("R4 held", uv_n, 1'b0);
        step(1);
        check("R4 release", uv_n, 1'b1);

        // R5: a returning fault restarts the count
        hi_below = 4'b0010; step(1);
        hi_below = '0; step(4);
        hi_below = 4'b0010; step(1);
        hi_below = '0; step(HOLD - 1);
        check("R5 restarted hold", uv_n, 1'b0);
        step(1);
        check("R5 release", uv_n, 1'b1);

        // R7: transparent overvoltage path
        lo_above = 4'b0001; step(1);
        check("R7 ov assert", ov_n, 1'b0);
        lo_above = '0; step(HOLD - 1);
        check("R7 ov held", ov_n, 1'b0);
        step(1);
        check("R7 ov release", ov_n, 1'b1);

        // R6: latched overvoltage, cleared by a high control
        latch_ctl = 1'b0;
        lo_above = 4'b0001; step(1);
        lo_above = '0; step(20);
        check("R6 latched", ov_n, 1'b0);
        latch_ctl = 1'b1; step(1);
        check("R6 cleared", ov_n, 1'b1);

        // R8: control dropped during the hold
        lo_above = 4'b0010; step(1);
        lo_above = '0; step(3);
        latch_ctl = 1'b0; step(15);
        check("R8 latched in hold", ov_n, 1'b0);
        latch_ctl = 1'b1; step(1);
        check("R8 cleared", ov_n, 1'b1);

        // R9: disable forces both outputs high
        dis_ctl = 1'b1;
        hi_below = 4'b0001; lo_above = 4'b0010; step(1);
        check("R9 dis uv", d_uv_n, 1'b1);
        check("R9 dis ov", d_ov_n, 1'b1);
        check("R4 latch build still asserts", uv_n, 1'b0);
        hi_below = '0; lo_above = '0;

        // R11: lockout under disable, immediate release
        lockout = 1'b1; step(1);
        check("R11 lockout uv", d_uv_n, 1'b0);
        check("R11 lockout ov", d_ov_n, 1'b1);
        lockout = 1'b0; step(1);
        check("R11 immediate release", d_uv_n, 1'b1);
        dis_ctl = 1'b0; step(HOLD + 2);

        // R10: lockout overrides faults, released through the hold
        lo_above = 4'b0001; lockout = 1'b1; step(1);
        check("R10 lockout uv", uv_n, 1'b0);
        check("R10 lockout ov blocked", ov_n, 1'b1);
        lockout = 1'b0; lo_above = '0; step(HOLD - 1);
        check("R10 uv held after lockout", uv_n, 1'b0);
        check("R10 ov discarded", ov_n, 1'b1);
        step(1);
        check("R10 uv release", uv_n, 1'b1);

        // R12: bypass releases on the first clear edge
        bypass_hold = 1'b1;
        hi_below = 4'b0001; step(1);
        check("R12 assert", uv_n, 1'b0);
        hi_below = '0; step(1);
        check("R12 immediate release", uv_n, 1'b1);
        bypass_hold = 1'b0;

        step(2);
        finish_run();
    end

endmodule